// File: doc/BRIEF.md
# Tile Dot-Product Matrix Accumulator

This block keeps a small register file of two-dimensional tiles and runs a matrix multiply-accumulate across them. Every tile element is a 32-bit word. For the multiply, that word is treated as four packed 8-bit lanes, and the lanes of two operands are reduced by a dot product. Each tile also carries its own active extent, a row count and a column count. The extent masks which leading rows and columns take part in a compute.

Software-side logic loads tiles one full row at a time through a row-wide write port, and it sets each tile's extent through a configuration port. It then issues a command that names a left source tile A, a right source tile B and an accumulator tile C, with a separate signedness flag for each operand. The block steps through the active part of C one element per cycle. It adds each element's sum of lane dot products into C and pulses `done_o` when the last element has been written. Results are fetched back a row at a time through the registered read port.

Top module: `tile_mac_acc`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low, every tile element is zero and every tile's extent reads back as 16 rows by 16 columns (both size-minus-one fields equal 15).
- R2: A cycle with `rd_en_i` high is followed, one cycle later, by `rd_valid_o` high. That cycle carries the addressed row on `rd_data_o`, with column c in bits [32c+31:32c], together with the tile's extent fields.
- R3: A `cfg_en_i` cycle sets the addressed tile's extent. The fields give the size minus one (0 means 1, 15 means 16), and the other tiles' extents are not changed.
- R4: In a product, lane j of an element is bits [8j+7:8j]. `a_signed_i` selects two's-complement lanes for A and unsigned lanes for A, and `b_signed_i` makes the same choice for B independently. The four lane products are summed.
- R5: A command leaves C[m][n] equal to its old value plus the sum over k of dot4(A[m][k], B[k][n]), reduced modulo 2^32 with no saturation.
- R6: An element of A with a row or column outside A's extent contributes zero. The same holds for an element of B outside B's extent, so a mismatch between A's columns and B's rows limits the sum to the smaller of the two.
- R7: Elements of C outside C's extent keep their values across a command.
- R8: `busy_o` rises in the cycle after a start is accepted and stays high for exactly rows(C) x cols(C) cycles. `done_o` is high for exactly the first cycle in which `busy_o` is low again.
- R9: While `busy_o` is high, start, tile-write and configuration requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write one tile row |
| wr_tile_i | input | 3 | Tile to write |
| wr_row_i | input | 4 | Row to write |
| wr_data_i | input | 512 | Row data, column c at bits [32c+31:32c] |
| cfg_en_i | input | 1 | Set a tile's extent |
| cfg_tile_i | input | 3 | Tile to configure |
| cfg_rows_m1_i | input | 4 | Active rows minus one |
| cfg_cols_m1_i | input | 4 | Active columns minus one |
| rd_en_i | input | 1 | Read one tile row |
| rd_tile_i | input | 3 | Tile to read |
| rd_row_i | input | 4 | Row to read |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 512 | Read row data |
| rd_rows_m1_o | output | 4 | Read tile's rows minus one |
| rd_cols_m1_o | output | 4 | Read tile's columns minus one |
| start_i | input | 1 | Start a multiply-accumulate |
| a_tile_i | input | 3 | Left source tile |
| b_tile_i | input | 3 | Right source tile |
| c_tile_i | input | 3 | Accumulator tile |
| a_signed_i | input | 1 | A lanes are signed |
| b_signed_i | input | 1 | B lanes are signed |
| busy_o | output | 1 | Compute in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is an operand whose stored contents extend past its configured extent. In that case A's column count and B's row count differ, so the masking decides the result. The stimulus first fills every tile with random data over all 16x16 positions and only afterwards shrinks the extents. As a result, stale non-zero words sit just outside the active region of A, B and C. The bench then reads back the whole accumulator tile, so a leak shows up either in an active element or as a change to an inactive one. Requests arriving during a compute are injected in the middle of a run, and they target a tile that is read back afterwards.

// File: rtl/tacc_pkg.sv
package tacc_pkg;
    localparam int ELEM_W = 32;
    localparam int LANES  = 4;
    localparam int LANE_W = ELEM_W / LANES;
    localparam int DIM_W  = 4;
    localparam int DIM    = 1 << DIM_W;
    localparam int ROW_W  = DIM * ELEM_W;

    typedef logic [ELEM_W-1:0] elem_t;

    typedef struct packed {
        logic [DIM_W-1:0] rows_m1;
        logic [DIM_W-1:0] cols_m1;
    } ext_t;
endpackage

// File: rtl/tacc_dot4.sv
module tacc_dot4
    import tacc_pkg::*;
(
    input  elem_t a_i,
    input  elem_t b_i,
    input  logic  a_sgn_i,
    input  logic  b_sgn_i,
    output elem_t dot_o
);
    logic signed [LANE_W:0]     la   [LANES];
    logic signed [LANE_W:0]     lb   [LANES];
    logic signed [2*LANE_W+1:0] prod [LANES];
    logic signed [ELEM_W-1:0]   acc;

    always_comb begin
        acc = '0;
        for (int j = 0; j < LANES; j++) begin
            la[j]   = {a_sgn_i & a_i[LANE_W*j+LANE_W-1], a_i[LANE_W*j +: LANE_W]};
            lb[j]   = {b_sgn_i & b_i[LANE_W*j+LANE_W-1], b_i[LANE_W*j +: LANE_W]};
            prod[j] = la[j] * lb[j];
            acc     = acc + ELEM_W'(prod[j]);
        end
        dot_o = acc;
    end

    // R4
    always_comb begin
        if (a_i == '0 || b_i == '0) begin
            zero_operand_chk: assert (dot_o == '0);
        end
    end
endmodule

// File: rtl/tacc_seq.sv
module tacc_seq
    import tacc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DIM_W-1:0] c_rows_m1_i,
    input  logic [DIM_W-1:0] c_cols_m1_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             step_o,
    output logic [DIM_W-1:0] m_o,
    output logic [DIM_W-1:0] n_o
);
    typedef struct packed {
        logic             busy;
        logic             done;
        logic [DIM_W-1:0] m;
        logic [DIM_W-1:0] n;
        logic [DIM_W-1:0] rmax;
        logic [DIM_W-1:0] cmax;
    } seq_t;

    seq_t s_d, s_q;
    logic last_q;

    assign last_q = (s_q.m == s_q.rmax) && (s_q.n == s_q.cmax);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.busy = 1'b1;
                s_d.m    = '0;
                s_d.n    = '0;
                s_d.rmax = c_rows_m1_i;
                s_d.cmax = c_cols_m1_i;
            end
        end else if (s_q.n == s_q.cmax) begin
            s_d.n = '0;
            if (s_q.m == s_q.rmax) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.m = s_q.m + 1'b1;
            end
        end else begin
            s_d.n = s_q.n + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o = s_q.busy;
    assign done_o = s_q.done;
    assign step_o = s_q.busy;
    assign m_o    = s_q.m;
    assign n_o    = s_q.n;

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> $past(s_q.busy) && !s_q.busy);

    // R7
    step_in_extent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.m <= s_q.rmax) && (s_q.n <= s_q.cmax));

    // R9
    restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !last_q) |=> s_q.busy && $stable(s_q.rmax) && $stable(s_q.cmax));
endmodule

// File: rtl/tile_mac_acc.sv
module tile_mac_acc
    import tacc_pkg::*;
#(
    parameter int NUM_TILES = 8,
    localparam int TW = $clog2(NUM_TILES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [TW-1:0]    wr_tile_i,
    input  logic [DIM_W-1:0] wr_row_i,
    input  logic [ROW_W-1:0] wr_data_i,
    input  logic             cfg_en_i,
    input  logic [TW-1:0]    cfg_tile_i,
    input  logic [DIM_W-1:0] cfg_rows_m1_i,
    input  logic [DIM_W-1:0] cfg_cols_m1_i,
    input  logic             rd_en_i,
    input  logic [TW-1:0]    rd_tile_i,
    input  logic [DIM_W-1:0] rd_row_i,
    output logic             rd_valid_o,
    output logic [ROW_W-1:0] rd_data_o,
    output logic [DIM_W-1:0] rd_rows_m1_o,
    output logic [DIM_W-1:0] rd_cols_m1_o,
    input  logic             start_i,
    input  logic [TW-1:0]    a_tile_i,
    input  logic [TW-1:0]    b_tile_i,
    input  logic [TW-1:0]    c_tile_i,
    input  logic             a_signed_i,
    input  logic             b_signed_i,
    output logic             busy_o,
    output logic             done_o
);
    typedef struct packed {
        ext_t [NUM_TILES-1:0] cfg;
        logic [TW-1:0]        a_t;
        logic [TW-1:0]        b_t;
        logic [TW-1:0]        c_t;
        logic                 a_sgn;
        logic                 b_sgn;
        logic                 rd_valid;
        logic [ROW_W-1:0]     rd_data;
        ext_t                 rd_ext;
    } top_t;

    top_t  st_d, st_q;
    elem_t mem_d [NUM_TILES][DIM][DIM];
    elem_t mem_q [NUM_TILES][DIM][DIM];

    logic             step;
    logic [DIM_W-1:0] m_idx, n_idx;
    ext_t             a_ext, b_ext, c_ext_new;
    elem_t            a_el  [DIM];
    elem_t            b_el  [DIM];
    elem_t            dot_k [DIM];
    logic [DIM-1:0]   k_live;
    logic             row_live;
    elem_t            dot_sum;

    assign c_ext_new = st_q.cfg[c_tile_i];

    tacc_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .c_rows_m1_i (c_ext_new.rows_m1),
        .c_cols_m1_i (c_ext_new.cols_m1),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .step_o      (step),
        .m_o         (m_idx),
        .n_o         (n_idx)
    );

    assign a_ext    = st_q.cfg[st_q.a_t];
    assign b_ext    = st_q.cfg[st_q.b_t];
    assign row_live = (m_idx <= a_ext.rows_m1) && (n_idx <= b_ext.cols_m1);

    for (genvar k = 0; k < DIM; k++) begin : g_k
        assign a_el[k]   = mem_q[st_q.a_t][m_idx][k];
        assign b_el[k]   = mem_q[st_q.b_t][k][n_idx];
        assign k_live[k] = (DIM_W'(k) <= a_ext.cols_m1) && (DIM_W'(k) <= b_ext.rows_m1);
        tacc_dot4 u_dot (
            .a_i     (a_el[k]),
            .b_i     (b_el[k]),
            .a_sgn_i (st_q.a_sgn),
            .b_sgn_i (st_q.b_sgn),
            .dot_o   (dot_k[k])
        );
    end

    always_comb begin
        dot_sum = '0;
        for (int k = 0; k < DIM; k++) begin
            if (k_live[k]) dot_sum = dot_sum + dot_k[k];
        end
        if (!row_live) dot_sum = '0;
    end

    always_comb begin
        st_d          = st_q;
        mem_d         = mem_q;
        st_d.rd_valid = rd_en_i;
        if (rd_en_i) begin
            for (int c = 0; c < DIM; c++) begin
                st_d.rd_data[c*ELEM_W +: ELEM_W] = mem_q[rd_tile_i][rd_row_i][c];
            end
            st_d.rd_ext = st_q.cfg[rd_tile_i];
        end
        if (!busy_o) begin
            if (wr_en_i) begin
                for (int c = 0; c < DIM; c++) begin
                    mem_d[wr_tile_i][wr_row_i][c] = wr_data_i[c*ELEM_W +: ELEM_W];
                end
            end
            if (cfg_en_i) begin
                st_d.cfg[cfg_tile_i].rows_m1 = cfg_rows_m1_i;
                st_d.cfg[cfg_tile_i].cols_m1 = cfg_cols_m1_i;
            end
            if (start_i) begin
                st_d.a_t   = a_tile_i;
                st_d.b_t   = b_tile_i;
                st_d.c_t   = c_tile_i;
                st_d.a_sgn = a_signed_i;
                st_d.b_sgn = b_signed_i;
            end
        end
        if (step) begin
            mem_d[st_q.c_t][m_idx][n_idx] = mem_q[st_q.c_t][m_idx][n_idx] + dot_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cfg <= '1;
            mem_q    <= '{default: '{default: '{default: '0}}};
        end else begin
            st_q     <= st_d;
            mem_q    <= mem_d;
        end
    end

    assign rd_valid_o   = st_q.rd_valid;
    assign rd_data_o    = st_q.rd_data;
    assign rd_rows_m1_o = st_q.rd_ext.rows_m1;
    assign rd_cols_m1_o = st_q.rd_ext.cols_m1;

    // R9
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(st_q.cfg));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R2
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_valid_o);
endmodule

// File: tb/sim_tile_mac_acc.sv
module sim_tile_mac_acc;
    import tacc_pkg::*;

    localparam int NT = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0, cfg_en = 1'b0, rd_en = 1'b0, start = 1'b0;
    logic [2:0]       wr_tile = '0, cfg_tile = '0, rd_tile = '0;
    logic [3:0]       wr_row = '0, rd_row = '0, cfg_r = '0, cfg_c = '0;
    logic [ROW_W-1:0] wr_data = '0;
    logic [2:0]       a_t = '0, b_t = '0, c_t = '0;
    logic             a_s = 1'b0, b_s = 1'b0;
    logic             rd_valid, busy, done;
    logic [ROW_W-1:0] rd_data;
    logic [3:0]       rd_r, rd_c;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    tile_mac_acc u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_tile_i(wr_tile), .wr_row_i(wr_row), .wr_data_i(wr_data),
        .cfg_en_i(cfg_en), .cfg_tile_i(cfg_tile), .cfg_rows_m1_i(cfg_r), .cfg_cols_m1_i(cfg_c),
        .rd_en_i(rd_en), .rd_tile_i(rd_tile), .rd_row_i(rd_row),
        .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_rows_m1_o(rd_r), .rd_cols_m1_o(rd_c),
        .start_i(start), .a_tile_i(a_t), .b_tile_i(b_t), .c_tile_i(c_t),
        .a_signed_i(a_s), .b_signed_i(b_s), .busy_o(busy), .done_o(done)
    );

    // shadow model
    int unsigned mdl [NT][16][16];
    int          mr  [NT];
    int          mc  [NT];

    typedef struct {
        logic [ROW_W-1:0] data;
        logic [3:0]       r;
        logic [3:0]       c;
        string            req;
    } item_t;
    item_t sb[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R2 unexpected read actual=1 expected=0");
            end else begin
                item_t it;
                it = sb.pop_front();
                if (rd_data !== it.data || rd_r !== it.r || rd_c !== it.c) begin
                    fails++;
                    $display("FAIL %s row actual=%h/%0d/%0d expected=%h/%0d/%0d",
                             it.req, rd_data, rd_r, rd_c, it.data, it.r, it.c);
                end
            end
        end
    end

    task automatic do_read(input int t, input int r, input string req);
        item_t it;
        for (int c = 0; c < 16; c++) it.data[c*32 +: 32] = mdl[t][r][c];
        it.r = 4'(mr[t] - 1);
        it.c = 4'(mc[t] - 1);
        it.req = req;
        @(negedge clk);
        sb.push_back(it);
        rd_en = 1'b1; rd_tile = 3'(t); rd_row = 4'(r);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic read_tile(input int t, input string req);
        for (int r = 0; r < 16; r++) do_read(t, r, req);
    endtask

    task automatic write_row(input int t, input int r, input logic [ROW_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_tile = 3'(t); wr_row = 4'(r); wr_data = d;
        for (int c = 0; c < 16; c++) mdl[t][r][c] = d[c*32 +: 32];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_ext(input int t, input int rows, input int cols);
        @(negedge clk);
        cfg_en = 1'b1; cfg_tile = 3'(t); cfg_r = 4'(rows - 1); cfg_c = 4'(cols - 1);
        mr[t] = rows; mc[t] = cols;
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    function automatic int lane(input int unsigned e, input int j, input bit sg);
        int v;
        v = int'((e >> (8 * j)) & 32'hFF);
        if (sg && v > 127) v = v - 256;
        return v;
    endfunction

    function automatic int unsigned dot4(input int unsigned x, input int unsigned y,
                                         input bit xs, input bit ys);
        int unsigned s = 0;
        for (int j = 0; j < 4; j++) s = s + int'(lane(x, j, xs) * lane(y, j, ys));
        return s;
    endfunction

    task automatic model_mm(input int a, input int b, input int c, input bit as, input bit bs);
        for (int m = 0; m < mr[c]; m++) begin
            for (int n = 0; n < mc[c]; n++) begin
                int unsigned s = mdl[c][m][n];
                for (int k = 0; k < 16; k++) begin
                    if (m < mr[a] && k < mc[a] && k < mr[b] && n < mc[b])
                        s = s + dot4(mdl[a][m][k], mdl[b][k][n], as, bs);
                end
                mdl[c][m][n] = s;
            end
        end
    endtask

    task automatic run_mm(input int a, input int b, input int c, input bit as, input bit bs,
                          input bit poke, input string req);
        int cycles = 0;
        model_mm(a, b, c, as, bs);
        @(negedge clk);
        start = 1'b1; a_t = 3'(a); b_t = 3'(b); c_t = 3'(c); a_s = as; b_s = bs;
        @(negedge clk);
        start = 1'b0;
        while (busy) begin
            cycles++;
            if (poke && cycles == 1) begin
                // R9: requests during a run must be ignored
                start = 1'b1; c_t = 3'd7; a_t = 3'd7; b_t = 3'd7;
                wr_en = 1'b1; wr_tile = 3'd7; wr_row = 4'd0; wr_data = {16{32'hDEAD_BEEF}};
                cfg_en = 1'b1; cfg_tile = 3'd7; cfg_r = 4'd0; cfg_c = 4'd0;
            end
            if (poke && cycles == 2) begin
                start = 1'b0; wr_en = 1'b0; cfg_en = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0; wr_en = 1'b0; cfg_en = 1'b0;
        check(cycles == mr[c] * mc[c], "R8", "busy cycles", cycles, mr[c] * mc[c]);
        check(done == 1'b1, "R8", "done at end", done, 1);
        @(negedge clk);
        check(done == 1'b0, "R8", "done single pulse", done, 0);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R9", "no restart", busy, 0);
        read_tile(c, req);
    endtask

    function automatic logic [ROW_W-1:0] rnd_row();
        logic [ROW_W-1:0] d;
        for (int c = 0; c < 16; c++) d[c*32 +: 32] = $urandom();
        return d;
    endfunction

    initial begin
        for (int t = 0; t < NT; t++) begin
            mr[t] = 16; mc[t] = 16;
            for (int r = 0; r < 16; r++)
                for (int c = 0; c < 16; c++) mdl[t][r][c] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(done == 1'b0, "R1", "done after reset", done, 0);
        do_read(3, 5, "R1");
        do_read(0, 15, "R1");

        // R2: fill tiles with random rows
        for (int t = 0; t < 7; t++)
            for (int r = 0; r < 16; r++) write_row(t, r, rnd_row());
        do_read(2, 4, "R2");
        do_read(6, 15, "R2");

        // R5 full 16x16 unsigned
        run_mm(4, 5, 6, 1'b0, 1'b0, 1'b0, "R5");

        // R3 extents, per tile
        set_ext(0, 3, 7);
        set_ext(1, 7, 5);
        set_ext(2, 3, 5);
        do_read(1, 0, "R3");
        do_read(3, 0, "R3");

        // R4 signed both, R6 and R7 via stale data outside extents
        run_mm(0, 1, 2, 1'b1, 1'b1, 1'b0, "R6");

        // R6 mismatched K: A cols 4, B rows 6; R4 mixed signedness
        set_ext(0, 5, 4);
        set_ext(1, 6, 9);
        set_ext(2, 5, 9);
        run_mm(0, 1, 2, 1'b1, 1'b0, 1'b0, "R4");
        run_mm(1, 0, 3, 1'b0, 1'b1, 1'b0, "R7");

        // R5 wrap modulo 2^32
        for (int r = 0; r < 16; r++) begin
            write_row(3, r, {16{32'hFFFF_FFFF}});
            write_row(4, r, {16{32'hFFFF_FFFF}});
            write_row(5, r, {16{32'hFFFF_FF00}});
        end
        set_ext(3, 16, 16);
        run_mm(3, 4, 5, 1'b0, 1'b0, 1'b0, "R5");
        run_mm(3, 4, 6, 1'b1, 1'b1, 1'b0, "R4");

        // R9 requests during a run
        write_row(7, 0, rnd_row());
        set_ext(2, 16, 16);
        set_ext(0, 16, 16);
        set_ext(1, 16, 16);
        run_mm(0, 1, 2, 1'b0, 1'b1, 1'b1, "R9");
        do_read(7, 0, "R9");

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R2", "pending reads", sb.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule